// File: doc/BRIEF.md
# Two-Sub-Phase Request Parity Generator and Checker

This block protects the request phase of a shared bus whose lines are active low. A request spans two consecutive clocks. In the first, the address lines carry a 35-bit address (address bits 37 down to 3). In the second, they carry transaction-type information. Two parity bits travel with every request. Each bit covers one half of the lines, and the two halves swap between the sub-phases. The block also covers the 3-bit response status field and its single parity bit.

All data inputs are logical values: a logical 1 means that the line is driven electrically low. All parity pins are electrical levels. As an initiator, the block computes the two request parity bits and the response parity bit combinationally from its inputs. As a receiver, a small state machine takes the cycle in which the address strobe becomes active as the first sub-phase and the next clock as the second sub-phase. In each of those cycles it recomputes both parity bits and raises one error flag per parity bit, registered, one clock later. The response field is checked on every clock.

Top module: `addr_parity_unit`

State machine (receiver side): `ST_IDLE` waits for the strobe. The transition `IDLE_TO_SUB2` is taken when `strobe` is high in `ST_IDLE`; that cycle is checked with the first-sub-phase mapping. `ST_SUB2` checks the current cycle with the second-sub-phase mapping. It then always takes `SUB2_TO_IDLE`.

## Requirements
- R1: In sub-phase 1, parity bit 0 covers address bits 37..24 (`addr_bits[34:21]`) together with all five `req_bits`, and parity bit 1 covers address bits 23..3 (`addr_bits[20:0]`).
- R2: In sub-phase 2 the groups swap. Parity bit 1 covers `addr_bits[34:21]` together with `req_bits`, and parity bit 0 covers `addr_bits[20:0]`. `par_out` uses the sub-phase 1 mapping when `sub_phase` is 0 and the sub-phase 2 mapping when `sub_phase` is 1.
- R3: A logical 1 on a data input means that the line is electrically low. A parity pin is 1 (high) when its group holds an even number of logical 1s, and 0 when the count is odd. With every covered line at logical 0, both bits of `par_out` are 1.
- R4: The receiver treats a cycle with `strobe` high in `ST_IDLE` as sub-phase 1 and the following clock as sub-phase 2. At the clock edge after each of those cycles, `par_err[k]` is set to 1 if `par_in[k]` differs from the recomputed bit k, and it stays high for exactly one clock.
- R5: In any cycle that is neither sub-phase 1 nor sub-phase 2 of a request, `par_in` is ignored and `par_err` is 0 at the next edge.
- R6: When one covered line is inverted against parity that was computed on the correct value, exactly one bit of `par_err` rises: the bit that covers that line in that sub-phase.
- R7: `rsp_par_out` follows the R3 rule over `rsp_bits`, so the idle (undriven) status `000` gives 1.
- R8: `rsp_err` is set at every clock edge to whether `rsp_par_in` differed from the recomputed response parity in the cycle before. The idle status `000` together with `rsp_par_in` = 1 is accepted; `000` with `rsp_par_in` = 0 is flagged.
- R9: While `rst_n` is low, the state machine returns to `ST_IDLE` and `par_err` and `rsp_err` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Address strobe, logical (1 = active), high in sub-phase 1 only |
| sub_phase | input | 1 | Generator mapping select: 0 = sub-phase 1, 1 = sub-phase 2 |
| addr_bits | input | 35 | Logical address lines; bit i is address bit i+3 |
| req_bits | input | 5 | Logical request-type lines |
| par_out | output | 2 | Generated request parity, electrical level, bit k = parity bit k |
| par_in | input | 2 | Received request parity, electrical level |
| par_err | output | 2 | Registered per-bit request parity error pulse |
| rsp_bits | input | 3 | Logical response status lines |
| rsp_par_out | output | 1 | Generated response parity, electrical level |
| rsp_par_in | input | 1 | Received response parity, electrical level |
| rsp_err | output | 1 | Registered response parity error |

## Verification
The assertions assume that a strobe never arrives in the clock right after another one, which would fall inside the second sub-phase of the earlier request. The stimulus keeps every request to a strobe cycle, a second cycle and at least one idle cycle. Outside a request, the stimulus may drive deliberately wrong request parity, so that the check that such values are ignored has something to ignore. The response inputs are driven on every clock, sometimes with deliberately wrong parity and including the idle status, because the response check runs continuously.

// File: rtl/apu_pkg.sv
package apu_pkg;
    localparam int ADDR_W = 35;
    localparam int LO_W   = 21;
    localparam int REQ_W  = 5;
    localparam int RSP_W  = 3;
    localparam int NPAR   = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SUB2 = 1'b1
    } apu_state_t;
endpackage

// File: rtl/apu_par_calc.sv
module apu_par_calc #(
    parameter int ADDR_W = 35,
    parameter int LO_W   = 21,
    parameter int REQ_W  = 5
) (
    input  logic [ADDR_W-1:0] addr_bits,
    input  logic [REQ_W-1:0]  req_bits,
    input  logic              second,
    output logic [1:0]        par
);
    localparam int HI_W = ADDR_W - LO_W + REQ_W;

    logic [HI_W-1:0] hi_grp;
    logic [LO_W-1:0] lo_grp;
    logic            hi_even;
    logic            lo_even;

    assign hi_grp  = {addr_bits[ADDR_W-1:LO_W], req_bits};
    assign lo_grp  = addr_bits[LO_W-1:0];
    // logical 1 = electrically low; the pin is high for an even count of lows
    assign hi_even = ~^hi_grp;
    assign lo_even = ~^lo_grp;

    always_comb begin
        if (second) par = {hi_even, lo_even};
        else        par = {lo_even, hi_even};
    end
endmodule

// File: rtl/apu_req_fsm.sv
module apu_req_fsm
    import apu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic chk_en,
    output logic chk_sub2
);
    apu_state_t state_q;
    apu_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        chk_en   = 1'b0;
        chk_sub2 = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (strobe) begin
                    chk_en  = 1'b1;
                    state_d = ST_SUB2;
                end
            end
            ST_SUB2: begin
                chk_en   = 1'b1;
                chk_sub2 = 1'b1;
                state_d  = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/apu_err_reg.sv
module apu_err_reg #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] expect_par,
    input  logic [N-1:0] rx_par,
    output logic [N-1:0] err
);
    for (genvar k = 0; k < N; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) err[k] <= 1'b0;
            else        err[k] <= en && (expect_par[k] != rx_par[k]);
        end
    end
endmodule

// File: rtl/addr_parity_unit.sv
module addr_parity_unit
    import apu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              sub_phase,
    input  logic [ADDR_W-1:0] addr_bits,
    input  logic [REQ_W-1:0]  req_bits,
    output logic [NPAR-1:0]   par_out,
    input  logic [NPAR-1:0]   par_in,
    output logic [NPAR-1:0]   par_err,
    input  logic [RSP_W-1:0]  rsp_bits,
    output logic              rsp_par_out,
    input  logic              rsp_par_in,
    output logic              rsp_err
);
    logic            chk_en;
    logic            chk_sub2;
    logic [NPAR-1:0] chk_par;

    apu_par_calc #(.ADDR_W(ADDR_W), .LO_W(LO_W), .REQ_W(REQ_W)) u_gen (
        .addr_bits (addr_bits),
        .req_bits  (req_bits),
        .second    (sub_phase),
        .par       (par_out)
    );

    apu_req_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (strobe),
        .chk_en   (chk_en),
        .chk_sub2 (chk_sub2)
    );

    apu_par_calc #(.ADDR_W(ADDR_W), .LO_W(LO_W), .REQ_W(REQ_W)) u_chk (
        .addr_bits (addr_bits),
        .req_bits  (req_bits),
        .second    (chk_sub2),
        .par       (chk_par)
    );

    apu_err_reg #(.N(NPAR)) u_req_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (chk_en),
        .expect_par (chk_par),
        .rx_par     (par_in),
        .err        (par_err)
    );

    assign rsp_par_out = ~^rsp_bits;

    apu_err_reg #(.N(1)) u_rsp_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (1'b1),
        .expect_par (rsp_par_out),
        .rx_par     (rsp_par_in),
        .err        (rsp_err)
    );
endmodule

// File: rtl/apu_checker.sv
module apu_checker
    import apu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              strobe,
    input logic [ADDR_W-1:0] addr_bits,
    input logic [REQ_W-1:0]  req_bits,
    input logic [NPAR-1:0]   par_out,
    input logic [NPAR-1:0]   par_err,
    input logic [RSP_W-1:0]  rsp_bits,
    input logic              rsp_par_out,
    input logic              rsp_par_in,
    input logic              rsp_err
);
    assert_strobe_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    assert_err_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|par_err) |-> ($past(strobe) || $past(strobe, 2)));

    assert_all_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr_bits == '0) && (req_bits == '0)) |-> (par_out == 2'b11));

    assert_rsp_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_bits == '0) |-> rsp_par_out);

    assert_rsp_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> $past(rsp_par_in != rsp_par_out));
endmodule

bind addr_parity_unit apu_checker u_apu_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .addr_bits   (addr_bits),
    .req_bits    (req_bits),
    .par_out     (par_out),
    .par_err     (par_err),
    .rsp_bits    (rsp_bits),
    .rsp_par_out (rsp_par_out),
    .rsp_par_in  (rsp_par_in),
    .rsp_err     (rsp_err)
);

// File: tb/tb_addr_parity_unit.sv
`timescale 1ns/1ps
module tb_addr_parity_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        strobe;
    logic        sub_phase;
    logic [34:0] addr_bits;
    logic [4:0]  req_bits;
    logic [1:0]  par_out;
    logic [1:0]  par_in;
    logic [1:0]  par_err;
    logic [2:0]  rsp_bits;
    logic        rsp_par_out;
    logic        rsp_par_in;
    logic        rsp_err;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;
    bit    m_second = 0;
    logic [1:0] exp_perr = 2'b00;
    logic  exp_rerr = 1'b0;
    string pend_tag = "R9";

    always #10 clk = ~clk;

    addr_parity_unit dut (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .sub_phase(sub_phase),
        .addr_bits(addr_bits), .req_bits(req_bits), .par_out(par_out),
        .par_in(par_in), .par_err(par_err), .rsp_bits(rsp_bits),
        .rsp_par_out(rsp_par_out), .rsp_par_in(rsp_par_in), .rsp_err(rsp_err)
    );

    // reference: count electrically low lines per group
    function automatic logic [1:0] ref_par(input bit second, input logic [34:0] a, input logic [4:0] q);
        int up = 0;
        int dn = 0;
        for (int i = 0; i < 35; i++) begin
            if (a[i]) begin
                if (i >= 21) up++;
                else dn++;
            end
        end
        for (int i = 0; i < 5; i++) if (q[i]) up++;
        if (!second) return {(dn % 2) == 0, (up % 2) == 0};
        else         return {(up % 2) == 0, (dn % 2) == 0};
    endfunction

    function automatic logic ref_rsp(input logic [2:0] r);
        int c = 0;
        for (int i = 0; i < 3; i++) if (r[i]) c++;
        return (c % 2) == 0;
    endfunction

    task automatic chk(input string tag, input string what, input logic [1:0] act, input logic [1:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, expv);
        end
    endtask

    task automatic step(input string tag, input logic s, input logic sp,
                        input logic [34:0] a, input logic [4:0] q, input logic [1:0] pin,
                        input logic [2:0] rb, input logic rpin);
        @(negedge clk);
        chk(pend_tag, "par_err", par_err, exp_perr);
        chk(pend_tag, "rsp_err", {1'b0, rsp_err}, {1'b0, exp_rerr});
        strobe = s; sub_phase = sp; addr_bits = a; req_bits = q;
        par_in = pin; rsp_bits = rb; rsp_par_in = rpin;
        #1;
        chk(tag, "par_out", par_out, ref_par(sp, a, q));
        chk(tag, "rsp_par_out", {1'b0, rsp_par_out}, {1'b0, ref_rsp(rb)});
        if (!m_second && s) begin
            exp_perr = pin ^ ref_par(1'b0, a, q);
            m_second = 1;
        end else if (m_second) begin
            exp_perr = pin ^ ref_par(1'b1, a, q);
            m_second = 0;
        end else begin
            exp_perr = 2'b00;
        end
        exp_rerr = (rpin != ref_rsp(rb));
        pend_tag = tag;
    endtask

    task automatic idle(input string tag);
        step(tag, 1'b0, 1'b0, '0, '0, 2'b11, 3'b000, 1'b1);
    endtask

    // a request with correct parity computed on base values, optional line flips
    task automatic request(input string tag,
                           input logic [34:0] a1, input logic [4:0] q1, input logic [34:0] fa1, input logic [4:0] fq1,
                           input logic [34:0] a2, input logic [4:0] q2, input logic [34:0] fa2, input logic [4:0] fq2);
        step(tag, 1'b1, 1'b0, a1 ^ fa1, q1 ^ fq1, ref_par(1'b0, a1, q1), 3'b000, 1'b1);
        step(tag, 1'b0, 1'b1, a2 ^ fa2, q2 ^ fq2, ref_par(1'b1, a2, q2), 3'b000, 1'b1);
        idle(tag);
    endtask

    initial begin
        rst_n = 1'b0; strobe = 0; sub_phase = 0; addr_bits = '0; req_bits = '0;
        par_in = 2'b11; rsp_bits = '0; rsp_par_in = 1'b1;
        repeat (3) @(posedge clk);
        // R9: erroneous inputs under reset must leave flags low
        @(negedge clk);
        par_in = 2'b00; rsp_par_in = 1'b0; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        #1;
        chk("R9", "par_err in reset", par_err, 2'b00);
        chk("R9", "rsp_err in reset", {1'b0, rsp_err}, 2'b00);
        par_in = 2'b11; rsp_par_in = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        idle("R9");
        idle("R3");
        // R3: all lines high gives high parity in both mappings
        step("R3", 1'b0, 1'b1, '0, '0, 2'b11, 3'b000, 1'b1);
        step("R3", 1'b0, 1'b0, '1, '1, 2'b11, 3'b111, 1'b0);
        idle("R3");
        // R1/R2 generation over patterns
        for (int i = 0; i < 24; i++) begin
            logic [34:0] a = {$urandom, $urandom};
            logic [4:0]  q = 5'($urandom);
            step("R1", 1'b0, 1'b0, a, q, 2'b11, 3'b000, 1'b1);
            step("R2", 1'b0, 1'b1, a, q, 2'b11, 3'b000, 1'b1);
        end
        step("R2", 1'b0, 1'b1, 35'h7_FFE0_0000, '0, 2'b11, 3'b000, 1'b1);
        step("R1", 1'b0, 1'b0, 35'h0_0000_0001, '0, 2'b11, 3'b000, 1'b1);
        idle("R1");
        // R4: clean requests raise no flag
        for (int i = 0; i < 8; i++) begin
            request("R4", {$urandom, $urandom}, 5'($urandom), '0, '0,
                          {$urandom, $urandom}, 5'($urandom), '0, '0);
        end
        // R4: wrong parity bits themselves, each sub-phase
        step("R4", 1'b1, 1'b0, 35'h1234_5678, 5'h0A, ~ref_par(1'b0, 35'h1234_5678, 5'h0A), 3'b000, 1'b1);
        step("R4", 1'b0, 1'b1, 35'h0ABC_DEF0, 5'h13, ref_par(1'b1, 35'h0ABC_DEF0, 5'h13) ^ 2'b10, 3'b000, 1'b1);
        idle("R4");
        idle("R4");
        // R5: wrong parity outside a request is ignored
        step("R5", 1'b0, 1'b0, 35'h5_5555_5555, 5'h15, 2'b00, 3'b000, 1'b1);
        step("R5", 1'b0, 1'b1, 35'h2_AAAA_AAAA, 5'h0A, ~ref_par(1'b1, 35'h2_AAAA_AAAA, 5'h0A), 3'b000, 1'b1);
        idle("R5");
        // R6: single line flips in each sub-phase
        for (int ph = 0; ph < 2; ph++) begin
            for (int ln = 0; ln < 40; ln++) begin
                logic [34:0] fa = '0;
                logic [4:0]  fq = '0;
                logic [34:0] a1 = {$urandom, $urandom};
                logic [34:0] a2 = {$urandom, $urandom};
                logic [4:0]  q1 = 5'($urandom);
                logic [4:0]  q2 = 5'($urandom);
                if (ln < 35) fa[ln] = 1'b1;
                else         fq[ln-35] = 1'b1;
                if (ph == 0) request("R6", a1, q1, fa, fq, a2, q2, '0, '0);
                else         request("R6", a1, q1, '0, '0, a2, q2, fa, fq);
            end
        end
        // R7/R8: response field, all codes, good and bad parity
        for (int r = 0; r < 8; r++) begin
            step("R7", 1'b0, 1'b0, '0, '0, 2'b11, 3'(r), ref_rsp(3'(r)));
            step("R8", 1'b0, 1'b0, '0, '0, 2'b11, 3'(r), ~ref_rsp(3'(r)));
        end
        step("R8", 1'b0, 1'b0, '0, '0, 2'b11, 3'b000, 1'b1);
        step("R8", 1'b0, 1'b0, '0, '0, 2'b11, 3'b000, 1'b0);
        idle("R8");
        idle("R8");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired, actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule